// File: doc/BRIEF.md
# Rotating and Mirroring Frame Address Generator

This block turns a raster walk over a source picture into a stream of frame-buffer addresses. The destination picture is the source mirrored horizontally, mirrored vertically and turned counterclockwise by a quarter-turn multiple, in any combination. A controller loads the picture size, two base addresses, a line stride and a 4-bit transform code with a single start pulse. The block then emits one destination address per source pixel, in source raster order, over a valid/ready channel. The pixel mover pairs each address with the pixel it fetches or stores.

On a fetch path the transform is free: the source is read in transformed order and the consumer sees an ordinary picture. On a store path the decoder still needs the untransformed picture as its motion-compensation reference. A second channel can therefore be enabled per picture. It carries the plain raster address of the same pixel into a separate reference buffer. A pixel is retired only when every enabled channel has taken its beat. When the last pixel is retired, a one-cycle completion pulse is raised.

Top module: `rotmir_addr_gen`

## Requirements
- R1: `cfg_mode` is decoded as bit 3 = horizontal mirror, bit 2 = vertical mirror, bits 1:0 = counterclockwise rotation code, where 0, 1, 2 and 3 mean 0, 90, 180 and 270 degrees. Each of the three controls acts independently.
- R2: For source pixel (x, y) of a W x H picture, mirroring is applied first: x becomes W-1-x when horizontal mirroring is on, and y becomes H-1-y when vertical mirroring is on. Rotation is applied next, one 90 degree counterclockwise step at a time. Each step maps (x, y) of a w x h picture to (y, w-1-x) of an h x w picture.
- R3: The transformed address is base + dy*stride + dx, where (dx, dy) is the R2 result. For rotation codes 1 and 3 the destination picture is H pixels wide and W rows tall.
- R4: With mode 0000, every transformed address equals base + y*stride + x of the source pixel.
- R5: Source pixels are visited in raster order: x counts fastest from 0 to W-1, then y advances, from row 0 to row H-1.
- R6: When the reference channel is enabled at start, it carries ref_base + y*stride + x for the same pixel as the transformed channel. When it is disabled, `id_valid` stays low for the whole picture and pixels retire on the transformed channel alone.
- R7: All configuration is captured only by a start pulse while the block is idle. A start pulse while busy has no effect on the picture in progress.
- R8: A raised `valid` stays high with a stable address until `ready` is seen. A channel that has delivered its beat does not repeat it while the other enabled channel is still pending.
- R9: `done` is high for exactly the cycle after the last pixel's final handshake. In that same cycle `busy` is low.
- R10: A start with zero width or zero height emits no beats and raises `done` in the next cycle.
- R11: After reset, `busy`, `xf_valid`, `id_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a picture with the current configuration |
| cfg_width | input | DW | Source width in pixels |
| cfg_height | input | DW | Source height in rows |
| cfg_base | input | AW | Base address of the transformed picture |
| cfg_ref_base | input | AW | Base address of the untransformed reference copy |
| cfg_stride | input | AW | Address distance between lines |
| cfg_mode | input | 4 | Mirror and rotation code |
| cfg_dual | input | 1 | Enable the reference address channel |
| busy | output | 1 | Picture in progress |
| xf_valid | output | 1 | Transformed address available |
| xf_ready | input | 1 | Transformed address accepted |
| xf_addr | output | AW | Transformed destination address |
| id_valid | output | 1 | Reference address available |
| id_ready | input | 1 | Reference address accepted |
| id_addr | output | AW | Reference (raster) address |
| done | output | 1 | One-cycle pulse after the last pixel |

## Verification
The hardest situation to reach is two enabled channels accepting their beats in different cycles. In that case one channel has already delivered and must stay silent while the other stalls, and the pixel must not advance. The bench drives both ready lines from a shift-register pattern with independent taps, so that every skew between them occurs several times in each picture. It checks that no address is duplicated, skipped or altered while a beat waits. A start pulse injected mid-picture with a different configuration exercises the idle-only capture rule.

// File: rtl/rotmir_pkg.sv
package rotmir_pkg;

  // Transform code layout; the field order is the decode order of cfg_mode.
  typedef struct packed {
    logic       hmir;
    logic       vmir;
    logic [1:0] rot;
  } mode_t;

  typedef enum logic [1:0] {
    ROT_0   = 2'd0,
    ROT_90  = 2'd1,
    ROT_180 = 2'd2,
    ROT_270 = 2'd3
  } rot_e;

  localparam int NUM_STREAMS = 2;
  localparam int STRM_XF     = 0;
  localparam int STRM_ID     = 1;

endpackage

// File: rtl/rotmir_cfg.sv
module rotmir_cfg
  import rotmir_pkg::*;
#(
  parameter int DW = 12,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] cfg_width,
  input  logic [DW-1:0] cfg_height,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_ref_base,
  input  logic [AW-1:0] cfg_stride,
  input  logic [3:0]    cfg_mode,
  input  logic          cfg_dual,
  output logic [DW-1:0] width_q,
  output logic [DW-1:0] height_q,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] ref_base_q,
  output logic [AW-1:0] stride_q,
  output mode_t         mode_q,
  output logic          dual_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q    <= '0;
      height_q   <= '0;
      base_q     <= '0;
      ref_base_q <= '0;
      stride_q   <= '0;
      mode_q     <= '0;
      dual_q     <= 1'b0;
    end else if (load) begin
      width_q    <= cfg_width;
      height_q   <= cfg_height;
      base_q     <= cfg_base;
      ref_base_q <= cfg_ref_base;
      stride_q   <= cfg_stride;
      mode_q     <= mode_t'(cfg_mode);
      dual_q     <= cfg_dual;
    end
  end

endmodule

// File: rtl/rotmir_scan.sv
module rotmir_scan #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          empty,
  input  logic          advance,
  input  logic [DW-1:0] width_q,
  input  logic [DW-1:0] height_q,
  output logic [DW-1:0] x_q,
  output logic [DW-1:0] y_q,
  output logic          last,
  output logic          busy_q,
  output logic          done_q
);

  logic x_end;
  logic y_end;

  assign x_end = (x_q == width_q - DW'(1));
  assign y_end = (y_q == height_q - DW'(1));
  assign last  = x_end & y_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load) begin
      x_q    <= '0;
      y_q    <= '0;
      busy_q <= ~empty;
      done_q <= empty;
    end else if (advance) begin
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (x_end) begin
        x_q    <= '0;
        y_q    <= y_q + DW'(1);
        done_q <= 1'b0;
      end else begin
        x_q    <= x_q + DW'(1);
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

endmodule

// File: rtl/rotmir_hs.sv
module rotmir_hs
  import rotmir_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   busy,
  input  logic                   dual,
  input  logic [NUM_STREAMS-1:0] rdy,
  output logic [NUM_STREAMS-1:0] vld,
  output logic                   advance
);

  logic [NUM_STREAMS-1:0] en;
  logic [NUM_STREAMS-1:0] taken;
  logic [NUM_STREAMS-1:0] ok;

  assign en[STRM_XF] = 1'b1;
  assign en[STRM_ID] = dual;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_strm
    logic tk;
    logic fire;
    assign taken[s] = tk;
    assign vld[s]   = busy & en[s] & ~tk;
    assign fire     = vld[s] & rdy[s];
    assign ok[s]    = ~en[s] | tk | fire;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 tk <= 1'b0;
      else if (advance || !busy)  tk <= 1'b0;
      else if (fire)              tk <= 1'b1;
    end
  end

  assign advance = busy & (&ok);

endmodule

// File: rtl/rotmir_xform.sv
module rotmir_xform
  import rotmir_pkg::*;
#(
  parameter int DW = 12,
  parameter int AW = 32
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic [DW-1:0] w,
  input  logic [DW-1:0] h,
  input  mode_t         mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] ref_base,
  input  logic [AW-1:0] stride,
  output logic [AW-1:0] xf_addr,
  output logic [AW-1:0] id_addr
);

  function automatic logic [DW-1:0] flip(input logic [DW-1:0] c,
                                         input logic [DW-1:0] n,
                                         input logic          en);
    return en ? (n - c - DW'(1)) : c;
  endfunction

  function automatic logic [AW-1:0] line_addr(input logic [AW-1:0] b,
                                              input logic [DW-1:0] row,
                                              input logic [DW-1:0] col,
                                              input logic [AW-1:0] st);
    return b + AW'(row) * st + AW'(col);
  endfunction

  logic [DW-1:0] mx, my;
  logic [DW-1:0] dx, dy;

  assign mx = flip(x, w, mode.hmir);
  assign my = flip(y, h, mode.vmir);

  always_comb begin
    unique case (rot_e'(mode.rot))
      ROT_90: begin
        dx = my;
        dy = w - mx - DW'(1);
      end
      ROT_180: begin
        dx = w - mx - DW'(1);
        dy = h - my - DW'(1);
      end
      ROT_270: begin
        dx = h - my - DW'(1);
        dy = mx;
      end
      default: begin
        dx = mx;
        dy = my;
      end
    endcase
  end

  assign xf_addr = line_addr(base, dy, dx, stride);
  assign id_addr = line_addr(ref_base, y, x, stride);

endmodule

// File: rtl/rotmir_addr_gen.sv
module rotmir_addr_gen
  import rotmir_pkg::*;
#(
  parameter int DW = 12,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] cfg_width,
  input  logic [DW-1:0] cfg_height,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_ref_base,
  input  logic [AW-1:0] cfg_stride,
  input  logic [3:0]    cfg_mode,
  input  logic          cfg_dual,
  output logic          busy,
  output logic          xf_valid,
  input  logic          xf_ready,
  output logic [AW-1:0] xf_addr,
  output logic          id_valid,
  input  logic          id_ready,
  output logic [AW-1:0] id_addr,
  output logic          done
);

  logic          start_take;
  logic          cfg_empty;
  logic          pix_advance;
  logic          pic_last;
  logic [DW-1:0] width_q, height_q;
  logic [AW-1:0] base_q, ref_base_q, stride_q;
  mode_t         mode_q;
  logic          dual_q;
  logic [DW-1:0] x_q, y_q;
  logic [NUM_STREAMS-1:0] rdy_vec, vld_vec;

  assign start_take = start & ~busy;
  assign cfg_empty  = (cfg_width == '0) | (cfg_height == '0);

  rotmir_cfg #(.DW(DW), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(start_take),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_base(cfg_base), .cfg_ref_base(cfg_ref_base),
    .cfg_stride(cfg_stride), .cfg_mode(cfg_mode), .cfg_dual(cfg_dual),
    .width_q(width_q), .height_q(height_q), .base_q(base_q),
    .ref_base_q(ref_base_q), .stride_q(stride_q),
    .mode_q(mode_q), .dual_q(dual_q)
  );

  rotmir_scan #(.DW(DW)) u_scan (
    .clk(clk), .rst_n(rst_n), .load(start_take), .empty(cfg_empty),
    .advance(pix_advance), .width_q(width_q), .height_q(height_q),
    .x_q(x_q), .y_q(y_q), .last(pic_last), .busy_q(busy), .done_q(done)
  );

  assign rdy_vec[STRM_XF] = xf_ready;
  assign rdy_vec[STRM_ID] = id_ready;

  rotmir_hs u_hs (
    .clk(clk), .rst_n(rst_n), .busy(busy), .dual(dual_q),
    .rdy(rdy_vec), .vld(vld_vec), .advance(pix_advance)
  );

  assign xf_valid = vld_vec[STRM_XF];
  assign id_valid = vld_vec[STRM_ID];

  rotmir_xform #(.DW(DW), .AW(AW)) u_xform (
    .x(x_q), .y(y_q), .w(width_q), .h(height_q), .mode(mode_q),
    .base(base_q), .ref_base(ref_base_q), .stride(stride_q),
    .xf_addr(xf_addr), .id_addr(id_addr)
  );

endmodule

// File: rtl/rotmir_addr_gen_chk.sv
module rotmir_addr_gen_chk #(
  parameter int DW = 12,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          xf_valid,
  input logic          xf_ready,
  input logic [AW-1:0] xf_addr,
  input logic          id_valid,
  input logic          id_ready,
  input logic [AW-1:0] id_addr,
  input logic          done,
  input logic          pix_advance,
  input logic          pic_last,
  input logic [3:0]    mode_q,
  input logic          dual_q,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] ref_base_q
);

  AST_XF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    xf_valid && !xf_ready |=> xf_valid && $stable(xf_addr)); // R8

  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && !id_ready |=> id_valid && $stable(id_addr)); // R8

  AST_ID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_q |-> !id_valid); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    pix_advance && pic_last |=> done && !busy); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xf_valid && !id_valid && !busy); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(mode_q) && $stable(base_q) && $stable(dual_q)); // R7

  AST_IDENT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    xf_valid && id_valid && mode_q == 4'b0000 |->
      (xf_addr - base_q) == (id_addr - ref_base_q)); // R4

  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xf_valid || id_valid |-> busy); // R8

endmodule

bind rotmir_addr_gen rotmir_addr_gen_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .xf_valid(xf_valid), .xf_ready(xf_ready), .xf_addr(xf_addr),
  .id_valid(id_valid), .id_ready(id_ready), .id_addr(id_addr),
  .done(done), .pix_advance(pix_advance), .pic_last(pic_last),
  .mode_q(mode_q), .dual_q(dual_q), .base_q(base_q), .ref_base_q(ref_base_q)
);

// File: tb/rotmir_addr_gen_test.sv
module rotmir_addr_gen_test;

  localparam int DW = 12;
  localparam int AW = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int STRIDE = 16;

  typedef struct packed {
    logic [7:0] w;
    logic [7:0] h;
    logic [3:0] mode;
    logic       dual;
    logic       pat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd4, 8'd3, 4'b0000, 1'b1, 1'b0},
    '{8'd4, 8'd3, 4'b0001, 1'b0, 1'b1},
    '{8'd5, 8'd2, 4'b0010, 1'b1, 1'b1},
    '{8'd3, 8'd4, 4'b0011, 1'b0, 1'b0},
    '{8'd4, 8'd3, 4'b1000, 1'b0, 1'b1},
    '{8'd4, 8'd3, 4'b0100, 1'b1, 1'b1},
    '{8'd3, 8'd2, 4'b1101, 1'b1, 1'b1},
    '{8'd2, 8'd5, 4'b1011, 1'b0, 1'b1},
    '{8'd1, 8'd1, 4'b1111, 1'b1, 1'b0},
    '{8'd6, 8'd1, 4'b0101, 1'b0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] cfg_width = '0, cfg_height = '0;
  logic [AW-1:0] cfg_base = '0, cfg_ref_base = '0, cfg_stride = '0;
  logic [3:0]    cfg_mode = '0;
  logic          cfg_dual = 1'b0;
  logic          busy, xf_valid, id_valid, done;
  logic          xf_ready = 1'b0, id_ready = 1'b0;
  logic [AW-1:0] xf_addr, id_addr;

  int nchk = 0;
  int nerr = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotmir_addr_gen #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_base(cfg_base), .cfg_ref_base(cfg_ref_base), .cfg_stride(cfg_stride),
    .cfg_mode(cfg_mode), .cfg_dual(cfg_dual),
    .busy(busy), .xf_valid(xf_valid), .xf_ready(xf_ready), .xf_addr(xf_addr),
    .id_valid(id_valid), .id_ready(id_ready), .id_addr(id_addr), .done(done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Independent model: mirror, then single CCW quarter-turns applied repeatedly.
  function automatic longint model_addr(int x, int y, int w, int h, logic [3:0] m, longint b);
    int cx = m[3] ? (w - 1 - x) : x;
    int cy = m[2] ? (h - 1 - y) : y;
    int cw = w, ch = h;
    for (int k = 0; k < int'(m[1:0]); k++) begin
      int nx = cy;
      int ny = cw - 1 - cx;
      int t  = cw;
      cx = nx; cy = ny; cw = ch; ch = t;
    end
    return b + longint'(cy) * STRIDE + cx;
  endfunction

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  // Runs one picture; intrude > 0 pulses start with junk config at that loop step.
  task automatic run_pic(input int w, input int h, input logic [3:0] m,
                         input logic dual, input logic pat, input int intrude);
    longint b  = 64'h1000 + longint'(m) * 64'h100;
    longint rb = 64'h8000;
    int n = w * h;
    int xi = 0, ii = 0;
    logic pxv = 0, pxr = 0, piv = 0, pir = 0;
    logic [AW-1:0] pxa = '0, pia = '0;
    @(negedge clk);
    cfg_width = DW'(w); cfg_height = DW'(h);
    cfg_base = AW'(b); cfg_ref_base = AW'(rb); cfg_stride = AW'(STRIDE);
    cfg_mode = m; cfg_dual = dual; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int step = 0; step < 2000; step++) begin
      if (!busy) begin
        check(done === 1'b1, "R9 done after last", done, 1);
        check(xi == n, "R5 transformed beat count", xi, n);
        check(ii == (dual ? n : 0), "R6 reference beat count", ii, dual ? n : 0);
        @(negedge clk);
        check(done === 1'b0, "R9 done single cycle", done, 0);
        return;
      end
      if (done) check(0, "R9 done while busy", done, 0);
      if (step == intrude) begin
        cfg_width = 12'd9; cfg_height = 12'd9; cfg_base = 32'hDEAD0000;
        cfg_mode = ~m; cfg_dual = ~dual; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (pxv && !pxr)
        check(xf_valid && xf_addr == pxa, "R8 xf hold", xf_addr, pxa);
      if (piv && !pir)
        check(id_valid && id_addr == pia, "R8 id hold", id_addr, pia);
      if (!dual && id_valid) check(0, "R6 id quiet", id_valid, 0);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      xf_ready = pat ? (lfsr[0] | lfsr[3]) : 1'b1;
      id_ready = pat ? (lfsr[5] | lfsr[8]) : 1'b1;
      if (xf_valid && xf_ready) begin
        longint e = model_addr(xi % w, xi / w, w, h, m, b);
        if (m == 4'b0000)
          check(xf_addr == AW'(e), "R4 identity mode addr", xf_addr, e);
        else
          check(xf_addr == AW'(e), "R1 R2 R3 transformed addr", xf_addr, e);
        xi++;
      end
      if (id_valid && id_ready) begin
        longint e = rb + longint'(ii / w) * STRIDE + (ii % w);
        check(id_addr == AW'(e), "R6 R5 reference addr", id_addr, e);
        ii++;
      end
      pxv = xf_valid; pxr = xf_ready; pxa = xf_addr;
      piv = id_valid; pir = id_ready; pia = id_addr;
      @(negedge clk);
    end
    check(0, "R9 picture did not finish", xi, n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary_and_end();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !xf_valid && !id_valid && !done, "R11 reset state",
          {busy, xf_valid, id_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R11 idle after reset", {busy, done}, 0);

    for (int i = 0; i < NV; i++)
      run_pic(VECS[i].w, VECS[i].h, VECS[i].mode, VECS[i].dual, VECS[i].pat, -1);

    // R7: start pulse while busy must not disturb the picture in progress
    run_pic(3, 2, 4'b0001, 1'b0, 1'b0, 2);
    run_pic(4, 2, 4'b0110, 1'b1, 1'b1, 3);

    // R10: zero-sized picture
    @(negedge clk);
    cfg_width = 12'd0; cfg_height = 12'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1, "R10 zero width done", done, 1);
    check(!busy && !xf_valid && !id_valid, "R10 zero width no beats",
          {busy, xf_valid, id_valid}, 0);
    @(negedge clk);
    cfg_width = 12'd5; cfg_height = 12'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1 && !xf_valid, "R10 zero height done", done, 1);

    // Back-to-back picture after empty one still works
    run_pic(2, 2, 4'b1110, 1'b1, 1'b1, -1);

    summary_and_end();
  end

endmodule